// File: doc/BRIEF.md
# Pixel-Doubling VGA Scanline Display Engine

This block drives a 640x480, 60 Hz VGA raster (25.175 MHz pixel clock) from a half-resolution 320x240 picture. Every source pixel is held for two pixel clocks, and every source line is shown on two successive display lines. Pixels come from an external scanline buffer made of 32-bit words. Each word packs four one-byte pixels, and each byte carries a 6-bit colour. A source line is therefore 80 words, and the block reads one word for every 8 output pixels.

The buffer read port is synchronous. The block presents an enable, a source-line index and a word index, and the buffer returns the word on the next clock. An external render pool fills the buffer. When the second display of a source line is finished, the block sends the pool a one-cycle request that names the next source line. Requests go out in strict ascending order and wrap at the end of the frame. The outputs are 2-bit red, green and blue plus active-low horizontal and vertical sync. The timing is parameterised so that a smaller raster can be used for test.

Top module: `vga_upscale_disp`

## Requirements
- R1: Each display line is H_VIS+H_FP+H_SYNC+H_BP pixel clocks long (defaults 640+16+96+48). `hsync_o` is low for exactly the H_SYNC clocks that begin H_VIS+H_FP clocks into the line, and high at all other times.
- R2: Each frame is V_VIS+V_FP+V_SYNC+V_BP lines long (defaults 480+10+2+33). `vsync_o` is low for all of the V_SYNC lines that begin V_VIS+V_FP lines into the frame.
- R3: `r_o`, `g_o` and `b_o` are zero on every clock whose column is at or beyond H_VIS, or whose line is at or beyond V_VIS.
- R4: Visible column x shows source pixel x/2, so each source pixel is driven for two consecutive clocks.
- R5: Display line y reads source line y/2 on `rd_line_o`, so each source line appears on two consecutive display lines.
- R6: Source pixel p of a word is byte p%4, taken least significant byte first. Within that byte, bits [5:4] drive `r_o`, bits [3:2] drive `g_o` and bits [1:0] drive `b_o`. Bits [7:6] are ignored.
- R7: On a visible line, `rd_en_o` is high only in columns x with x%8==0, and then `rd_word_o` equals x/8. The buffer returns the word on the following clock.
- R8: On the first horizontal blanking clock of every odd visible line y, `req_o` pulses for one cycle. At the same time `req_line_o` gives (y+1)/2, or 0 when y is the last visible line.
- R9: During reset the RGB outputs and `req_o` are 0 and both syncs are high. Pixel and sync outputs lag the raster counters by two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_o | output | 1 | Scanline buffer read enable |
| rd_line_o | output | LINE_W | Source line index of the read |
| rd_word_o | output | WORD_W | Word index within the source line |
| rd_data_i | input | 32 | Read word, valid one clock after rd_en_o |
| req_o | output | 1 | Next-line request pulse to the render pool |
| req_line_o | output | LINE_W | Source line index being requested |
| r_o | output | 2 | Red |
| g_o | output | 2 | Green |
| b_o | output | 2 | Blue |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |

## Verification
If the column counter is off by one, the sync pulse moves and the pixels shift on the very next line. If the word or byte select is wrong, a visibly wrong colour or a wrong read index appears within 8 clocks. If the vertical halving is wrong, `rd_line_o` disagrees with the model on the second display line of a source line. A request that is missing, late or carries the wrong index shows up in the first odd line's blanking interval. The wrap back to line 0 shows up at the end of the first frame.

// File: rtl/vga_up_pkg.sv
package vga_up_pkg;

  typedef struct packed {
    logic [1:0] r;
    logic [1:0] g;
    logic [1:0] b;
  } rgb_t;

  function automatic rgb_t px_to_rgb(input logic [5:0] px);
    rgb_t c;
    c.r = px[5:4];
    c.g = px[3:2];
    c.b = px[1:0];
    return c;
  endfunction

endpackage

// File: rtl/vga_up_timing.sv
module vga_up_timing #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  localparam int HT    = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int VT    = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW    = $clog2(HT),
  localparam int VW    = $clog2(VT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic          vis_o,
  output logic          hsync_n_o,
  output logic          vsync_n_o
);

  localparam logic [HW-1:0] HLast = HW'(HT - 1);
  localparam logic [VW-1:0] VLast = VW'(VT - 1);
  localparam logic [HW-1:0] HVis  = HW'(H_VIS);
  localparam logic [VW-1:0] VVis  = VW'(V_VIS);
  localparam logic [HW-1:0] HS0   = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS1   = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS0   = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS1   = VW'(V_VIS + V_FP + V_SYNC);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_q == HLast) begin
      h_q <= '0;
      v_q <= (v_q == VLast) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign h_o       = h_q;
  assign v_o       = v_q;
  assign vis_o     = (h_q < HVis) && (v_q < VVis);
  assign hsync_n_o = !((h_q >= HS0) && (h_q < HS1));
  assign vsync_n_o = !((v_q >= VS0) && (v_q < VS1));

  // R1
  h_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_q == HLast) |=> (h_q == '0));

  // R2
  v_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_q != HLast) |=> $stable(v_q));

endmodule

// File: rtl/vga_up_unpack.sv
module vga_up_unpack
  import vga_up_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fetch_d1_i,
  input  logic [1:0]  sel_i,
  input  logic [31:0] rd_data_i,
  output rgb_t        pix_o
);

  logic [31:0] word_q;
  logic [31:0] word;
  logic [7:0]  byte_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         word_q <= '0;
    else if (fetch_d1_i) word_q <= rd_data_i;
  end

  // first pixel of a word comes straight from the buffer, the rest from the hold register
  assign word     = fetch_d1_i ? rd_data_i : word_q;
  assign byte_sel = word[8*sel_i +: 8];
  assign pix_o    = px_to_rgb(byte_sel[5:0]);

  // R6
  first_pix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_d1_i |-> (sel_i == 2'd0));

endmodule

// File: rtl/vga_upscale_disp.sv
module vga_upscale_disp
  import vga_up_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  localparam int HT     = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int VT     = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW     = $clog2(HT),
  localparam int VW     = $clog2(VT),
  localparam int WORD_W = $clog2(H_VIS / 8),
  localparam int LINE_W = $clog2(V_VIS / 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              rd_en_o,
  output logic [LINE_W-1:0] rd_line_o,
  output logic [WORD_W-1:0] rd_word_o,
  input  logic [31:0]       rd_data_i,
  output logic              req_o,
  output logic [LINE_W-1:0] req_line_o,
  output logic [1:0]        r_o,
  output logic [1:0]        g_o,
  output logic [1:0]        b_o,
  output logic              hsync_o,
  output logic              vsync_o
);

  localparam logic [HW-1:0] HVis  = HW'(H_VIS);
  localparam logic [VW-1:0] VVis  = VW'(V_VIS);
  localparam logic [VW-1:0] VLast = VW'(V_VIS - 1);

  logic [HW-1:0] h;
  logic [VW-1:0] v;
  logic          vis, hs_n, vs_n;

  vga_up_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) i_timing (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .h_o       (h),
    .v_o       (v),
    .vis_o     (vis),
    .hsync_n_o (hs_n),
    .vsync_n_o (vs_n)
  );

  // one word covers 8 output pixels
  assign rd_en_o   = vis && (h[2:0] == 3'd0);
  assign rd_word_o = WORD_W'(h >> 3);
  assign rd_line_o = LINE_W'(v >> 1);

  logic              req_c;
  logic [LINE_W-1:0] next_line_c;
  assign req_c       = (h == HVis) && (v < VVis) && v[0];
  assign next_line_c = (v == VLast) ? '0 : LINE_W'((v >> 1) + 1'b1);

  logic              vis_d1, hs_d1, vs_d1, en_d1, req_d1;
  logic [1:0]        sel_d1;
  logic [LINE_W-1:0] nl_d1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_d1 <= 1'b0;
      hs_d1  <= 1'b1;
      vs_d1  <= 1'b1;
      en_d1  <= 1'b0;
      req_d1 <= 1'b0;
      sel_d1 <= '0;
      nl_d1  <= '0;
    end else begin
      vis_d1 <= vis;
      hs_d1  <= hs_n;
      vs_d1  <= vs_n;
      en_d1  <= rd_en_o;
      req_d1 <= req_c;
      sel_d1 <= h[2:1];
      nl_d1  <= next_line_c;
    end
  end

  rgb_t pix;

  vga_up_unpack i_unpack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fetch_d1_i (en_d1),
    .sel_i      (sel_d1),
    .rd_data_i  (rd_data_i),
    .pix_o      (pix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {r_o, g_o, b_o} <= '0;
      hsync_o    <= 1'b1;
      vsync_o    <= 1'b1;
      req_o      <= 1'b0;
      req_line_o <= '0;
    end else begin
      {r_o, g_o, b_o} <= vis_d1 ? pix : '0;
      hsync_o    <= hs_d1;
      vsync_o    <= vs_d1;
      req_o      <= req_d1;
      if (req_d1) req_line_o <= nl_d1;
    end
  end

  // R3
  blank_rgb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vis_d1 |=> ({r_o, g_o, b_o} == '0));

  // R7
  fetch_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);

  // R8
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

endmodule

// File: tb/test_vga_upscale_disp.sv
module test_vga_upscale_disp;

  localparam int H_VIS = 32, H_FP = 2, H_SYNC = 4, H_BP = 2;
  localparam int V_VIS = 8,  V_FP = 1, V_SYNC = 2, V_BP = 2;
  localparam int HT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int VT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int WORD_W = $clog2(H_VIS / 8);
  localparam int LINE_W = $clog2(V_VIS / 2);
  localparam int RUN = 3 * HT * VT + 20;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              rd_en_o;
  logic [LINE_W-1:0] rd_line_o;
  logic [WORD_W-1:0] rd_word_o;
  logic [31:0]       rd_data_i = '0;
  logic              req_o;
  logic [LINE_W-1:0] req_line_o;
  logic [1:0]        r_o, g_o, b_o;
  logic              hsync_o, vsync_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  vga_upscale_disp #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) i_vga_upscale_disp (
    .clk_i, .rst_ni, .rd_en_o, .rd_line_o, .rd_word_o, .rd_data_i,
    .req_o, .req_line_o, .r_o, .g_o, .b_o, .hsync_o, .vsync_o
  );

  function automatic logic [31:0] src_word(input int line, input int word);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = 8'(line * 29 + word * 11 + k * 53 + 7);
    return w;
  endfunction

  // behavioural scanline buffer, one-clock read latency
  always @(posedge clk_i)
    if (rd_en_o) rd_data_i <= src_word(int'(rd_line_o), int'(rd_word_o));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk({r_o, g_o, b_o} == 6'd0, "R9", "rgb in reset", {r_o, g_o, b_o}, 0);
    chk(hsync_o && vsync_o, "R9", "syncs in reset", {hsync_o, vsync_o}, 3);
    chk(!req_o, "R9", "req in reset", req_o, 0);
    rst_ni = 1'b1;
    for (int cyc = 0; cyc < RUN; cyc++) begin
      if (cyc > 0) @(negedge clk_i);
      begin
        int fh, fv, h, v;
        int e_rgb, e_hs, e_vs, e_req, e_nl;
        bit e_vis;
        fh = cyc % HT;
        fv = (cyc / HT) % VT;
        // read port follows the current raster position (R5, R7)
        e_vis = (fh < H_VIS) && (fv < V_VIS);
        chk(rd_en_o == (e_vis && fh % 8 == 0), "R7", "rd_en", rd_en_o, e_vis && fh % 8 == 0);
        if (rd_en_o && e_vis) begin
          chk(int'(rd_word_o) == fh / 8, "R7", "rd_word", rd_word_o, fh / 8);
          chk(int'(rd_line_o) == fv / 2, "R5", "rd_line", rd_line_o, fv / 2);
        end
        // pixel path lags the raster by two clocks (R9)
        if (cyc >= 2) begin
          h = (cyc - 2) % HT;
          v = ((cyc - 2) / HT) % VT;
          e_hs = !(h >= H_VIS + H_FP && h < H_VIS + H_FP + H_SYNC);
          e_vs = !(v >= V_VIS + V_FP && v < V_VIS + V_FP + V_SYNC);
          e_req = (h == H_VIS) && (v < V_VIS) && (v % 2 == 1);
          e_nl = (v == V_VIS - 1) ? 0 : (v + 1) / 2;
          if (h < H_VIS && v < V_VIS) begin
            logic [31:0] w;
            logic [7:0] b;
            w = src_word(v / 2, h / 8);
            b = w[8 * ((h / 2) % 4) +: 8];
            e_rgb = int'(b[5:0]);
            chk({r_o, g_o, b_o} == 6'(e_rgb), "R4 R5 R6", "pixel", {r_o, g_o, b_o}, e_rgb);
          end else begin
            chk({r_o, g_o, b_o} == 6'd0, "R3", "blank rgb", {r_o, g_o, b_o}, 0);
          end
        end else begin
          e_hs = 1; e_vs = 1; e_req = 0; e_nl = 0;
          chk({r_o, g_o, b_o} == 6'd0, "R9", "rgb after reset", {r_o, g_o, b_o}, 0);
        end
        chk(hsync_o == 1'(e_hs), "R1", "hsync", hsync_o, e_hs);
        chk(vsync_o == 1'(e_vs), "R2", "vsync", vsync_o, e_vs);
        chk(req_o == 1'(e_req), "R8", "req", req_o, e_req);
        if (e_req) chk(int'(req_line_o) == e_nl, "R8", "req_line", req_line_o, e_nl);
      end
    end
    summary();
  end

endmodule